// File: doc/BRIEF.md
# Display register command-queue executor

This block walks a list of register-programming instructions held in memory and carries each one out against a register write port. Software loads a start address while the engine is idle. It then writes the end address, and that write launches the run. The engine fetches one 32-bit word at a time through a valid/ready read port and decodes instructions that are two words long. It stops when its fetch address equals the end address.

The instructions cover five jobs. A plain write carries byte enables. An indexed burst sends a counted run of data words to one register. Two waits count either microsecond ticks or vblank pulses. A line-window wait is handed to an outside scanline comparator through a request/done pair. An interrupt instruction sets a sticky status bit. The engine never reads registers. A poll or an unknown opcode sets an error bit and ends the run. A halt input stops execution at the next safe point.

Top module: `disp_cmdq_exec`

## Requirements
- R1: After reset, busy, prog_irq, err, mrd_req_valid, rw_valid and win_req are all low.
- R2: Opcode 0x01 (upper word bits 31:24) gives one rw_valid pulse. rw_be is upper bits 23:20, rw_offset is upper bits 19:0 and rw_data is the lower word. Instructions execute in memory order, and opcode 0x00 has no effect.
- R3: Opcode 0x09 takes a count N from its lower word. The next N words are each written to offset upper[19:0] with rw_be = 4'hF. When N is odd, one pad word follows that produces no write. N = 0 writes nothing.
- R4: The run ends, and busy falls, once the fetch address equals the end address. Words at or beyond the end address are never fetched.
- R5: A write to tail_we while idle and not halted starts a run at the stored head, provided head bits 5:0 are zero. If they are not, err is set and nothing is fetched. While busy, tail_we and head_we have no effect.
- R6: Opcode 0x02 holds execution until the number of us_tick pulses given by its lower word has arrived. A count of 0 does not wait, and vblank pulses do not count.
- R7: Opcode 0x04 holds execution until the number of vblank pulses given by its lower word has arrived. us_tick pulses do not count.
- R8: Opcodes 0x05 and 0x06 raise win_req until win_done. win_lo is lower[19:0], win_hi is {upper[7:0], lower[31:20]}, and win_inside is 1 for 0x05 and 0 for 0x06. Opcode 0x03 does the same with win_lo = win_hi = lower[19:0] and win_inside = 1.
- R9: Opcode 0x07 sets prog_irq, which holds until an irq_clr pulse. When both happen in the same cycle, the set takes priority.
- R10: Opcode 0x0A, and any opcode outside the defined set, sets err and ends the run with no further writes. The next accepted start clears err.
- R11: When halt is high, a run that is waiting, writing or about to fetch goes idle at the next edge. A run with a read outstanding goes idle once the response arrives.
- R12: At most one read is outstanding. mrd_req_addr holds steady while a request waits for ready, and successive fetch addresses rise by 4 from the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_we | input | 1 | Load start address (idle only) |
| head_wdata | input | AW | Start byte address |
| tail_we | input | 1 | Load end address and launch |
| tail_wdata | input | AW | End byte address |
| halt | input | 1 | Stop execution |
| irq_clr | input | 1 | Clear program interrupt |
| busy | output | 1 | Run in progress |
| prog_irq | output | 1 | Sticky program interrupt |
| err | output | 1 | Bad opcode or misaligned start |
| mrd_req_valid | output | 1 | Read request valid |
| mrd_req_ready | input | 1 | Read request accepted |
| mrd_req_addr | output | AW | Read byte address |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_data | input | 32 | Read data |
| rw_valid | output | 1 | Register write strobe |
| rw_offset | output | 20 | Register offset |
| rw_be | output | 4 | Byte enables |
| rw_data | output | 32 | Write data |
| us_tick | input | 1 | Microsecond tick pulse |
| vblank | input | 1 | Vblank pulse |
| win_req | output | 1 | Line-window wait request |
| win_inside | output | 1 | 1: wait inside window, 0: outside |
| win_lo | output | 20 | Window first line |
| win_hi | output | 20 | Window last line |
| win_done | input | 1 | Comparator reports wait over |

## Verification
The hardest case to reach is the indexed burst that straddles pad words, and it must be reached while responses return late and ready is withheld every other cycle. If the pad decision slips by one word, the instruction stream desynchronises. To cover this, one program with odd, even, zero and single-word bursts is replayed under every combination of response latency 0–3 and two ready patterns. The resulting write log and the fetch address sequence are checked each time. The bench also delivers tick, vblank and window-done pulses only once the engine is parked in a wait. It checks that the wrong pulse kind, or one pulse too few, leaves the next write unissued.

// File: rtl/disp_cmdq_exec.sv
module disp_cmdq_exec #(
  parameter int AW   = 16,
  parameter int CNTW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_we,
  input  logic [AW-1:0] head_wdata,
  input  logic          tail_we,
  input  logic [AW-1:0] tail_wdata,
  input  logic          halt,
  input  logic          irq_clr,
  output logic          busy,
  output logic          prog_irq,
  output logic          err,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [AW-1:0] mrd_req_addr,
  input  logic          mrd_rsp_valid,
  input  logic [31:0]   mrd_rsp_data,
  output logic          rw_valid,
  output logic [19:0]   rw_offset,
  output logic [3:0]    rw_be,
  output logic [31:0]   rw_data,
  input  logic          us_tick,
  input  logic          vblank,
  output logic          win_req,
  output logic          win_inside,
  output logic [19:0]   win_lo,
  output logic [19:0]   win_hi,
  input  logic          win_done
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [7:0] OP_NOP = 8'h00, OP_WR = 8'h01, OP_WUS = 8'h02,
                         OP_WLN = 8'h03, OP_WVB = 8'h04, OP_WIN = 8'h05,
                         OP_WOUT = 8'h06, OP_IRQ = 8'h07, OP_IDX = 8'h09;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RSP, S_WR, S_WAIT, S_WIN} state_t;
  typedef enum logic [1:0] {K_LO, K_HI, K_DAT, K_PAD} kind_t;

  state_t          state;
  kind_t           kind;
  logic [AW-1:0]   head, tail, addr;
  logic [31:0]     lo;
  logic [7:0]      op_q, upx;
  logic [CNTW-1:0] cnt;
  logic            wait_vb;
  logic [19:0]     wr_off;
  logic [3:0]      wr_be;
  logic [31:0]     wr_data;

  wire [7:0]    rsp_op   = mrd_rsp_data[31:24];
  wire          got      = (state == S_RSP) && mrd_rsp_valid;
  wire          irq_set  = got && (kind == K_HI) && (rsp_op == OP_IRQ);
  wire [AW-1:0] nxt_addr = addr + STEP;
  wire          tick     = wait_vb ? vblank : us_tick;

  assign busy          = (state != S_IDLE);
  assign mrd_req_valid = (state == S_REQ) && !halt && (addr != tail);
  assign mrd_req_addr  = addr;
  assign rw_valid      = (state == S_WR);
  assign rw_offset     = wr_off;
  assign rw_be         = wr_be;
  assign rw_data       = wr_data;
  assign win_req       = (state == S_WIN);
  assign win_inside    = (op_q != OP_WOUT);
  assign win_lo        = lo[19:0];
  assign win_hi        = (op_q == OP_WLN) ? lo[19:0] : {upx, lo[31:20]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_LO;
      head     <= '0;
      tail     <= '0;
      addr     <= '0;
      lo       <= '0;
      op_q     <= '0;
      upx      <= '0;
      cnt      <= '0;
      wait_vb  <= 1'b0;
      wr_off   <= '0;
      wr_be    <= '0;
      wr_data  <= '0;
      prog_irq <= 1'b0;
      err      <= 1'b0;
    end else begin
      prog_irq <= irq_set | (prog_irq & ~irq_clr);
      case (state)
        S_IDLE: begin
          if (head_we) head <= head_wdata;
          if (tail_we && !halt) begin
            if (head[5:0] != 6'd0) begin
              err <= 1'b1;
            end else begin
              err   <= 1'b0;
              tail  <= tail_wdata;
              addr  <= head;
              kind  <= K_LO;
              state <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (halt || addr == tail) state <= S_IDLE;
          else if (mrd_req_ready)   state <= S_RSP;
        end
        S_RSP: begin
          if (mrd_rsp_valid) begin
            addr <= nxt_addr;
            case (kind)
              K_LO: begin
                lo    <= mrd_rsp_data;
                kind  <= K_HI;
                state <= S_REQ;
              end
              K_HI: begin
                op_q <= rsp_op;
                upx  <= mrd_rsp_data[7:0];
                kind <= K_LO;
                case (rsp_op)
                  OP_NOP, OP_IRQ: state <= S_REQ;
                  OP_WR: begin
                    wr_off  <= mrd_rsp_data[19:0];
                    wr_be   <= mrd_rsp_data[23:20];
                    wr_data <= lo;
                    state   <= S_WR;
                  end
                  OP_WUS, OP_WVB: begin
                    cnt     <= CNTW'(lo);
                    wait_vb <= (rsp_op == OP_WVB);
                    state   <= S_WAIT;
                  end
                  OP_WLN, OP_WIN, OP_WOUT: state <= S_WIN;
                  OP_IDX: begin
                    wr_off <= mrd_rsp_data[19:0];
                    cnt    <= CNTW'(lo);
                    kind   <= (lo == 32'd0) ? K_LO : K_DAT;
                    state  <= S_REQ;
                  end
                  default: begin
                    err   <= 1'b1;
                    state <= S_IDLE;
                  end
                endcase
              end
              K_DAT: begin
                wr_data <= mrd_rsp_data;
                wr_be   <= 4'hF;
                cnt     <= cnt - CNTW'(1);
                if (cnt == CNTW'(1)) kind <= nxt_addr[2] ? K_PAD : K_LO;
                state   <= S_WR;
              end
              default: begin
                kind  <= K_LO;
                state <= S_REQ;
              end
            endcase
          end
        end
        S_WR: state <= halt ? S_IDLE : S_REQ;
        S_WAIT: begin
          if (halt)                 state <= S_IDLE;
          else if (cnt == '0)       state <= S_REQ;
          else if (tick)            cnt   <= cnt - CNTW'(1);
        end
        S_WIN: begin
          if (halt)          state <= S_IDLE;
          else if (win_done) state <= S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module disp_cmdq_exec_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          halt,
  input logic          prog_irq,
  input logic          irq_clr,
  input logic          err,
  input logic          mrd_req_valid,
  input logic          mrd_req_ready,
  input logic [AW-1:0] mrd_req_addr,
  input logic          mrd_rsp_valid,
  input logic          rw_valid,
  input logic          win_req
);
  logic outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mrd_req_valid && mrd_req_ready) outst <= 1'b1;
    else if (mrd_rsp_valid) outst <= 1'b0;
  end

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mrd_req_valid);
  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req_valid && !mrd_req_ready) |=> $stable(mrd_req_addr));
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |=> !rw_valid);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rw_valid && !mrd_req_valid));
  p_win_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_req |-> busy);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_irq && !irq_clr) |=> prog_irq);
  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  p_halt_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !outst) |=> !busy);
endmodule

bind disp_cmdq_exec disp_cmdq_exec_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .halt(halt), .prog_irq(prog_irq),
  .irq_clr(irq_clr), .err(err), .mrd_req_valid(mrd_req_valid),
  .mrd_req_ready(mrd_req_ready), .mrd_req_addr(mrd_req_addr),
  .mrd_rsp_valid(mrd_rsp_valid), .rw_valid(rw_valid), .win_req(win_req)
);

// File: tb/disp_cmdq_exec_bench.sv
module disp_cmdq_exec_bench;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_we = 1'b0, tail_we = 1'b0, halt = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] head_wdata = '0, tail_wdata = '0;
  logic busy, prog_irq, err, mrd_req_valid, mrd_req_ready, mrd_rsp_valid;
  logic [AW-1:0] mrd_req_addr;
  logic [31:0] mrd_rsp_data;
  logic rw_valid;
  logic [19:0] rw_offset;
  logic [3:0] rw_be;
  logic [31:0] rw_data;
  logic us_tick = 1'b0, vblank = 1'b0, win_done = 1'b0;
  logic win_req, win_inside;
  logic [19:0] win_lo, win_hi;

  disp_cmdq_exec #(.AW(AW)) u_disp_cmdq_exec (
    .clk(clk), .rst_n(rst_n), .head_we(head_we), .head_wdata(head_wdata),
    .tail_we(tail_we), .tail_wdata(tail_wdata), .halt(halt), .irq_clr(irq_clr),
    .busy(busy), .prog_irq(prog_irq), .err(err),
    .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready),
    .mrd_req_addr(mrd_req_addr), .mrd_rsp_valid(mrd_rsp_valid),
    .mrd_rsp_data(mrd_rsp_data), .rw_valid(rw_valid), .rw_offset(rw_offset),
    .rw_be(rw_be), .rw_data(rw_data), .us_tick(us_tick), .vblank(vblank),
    .win_req(win_req), .win_inside(win_inside), .win_lo(win_lo),
    .win_hi(win_hi), .win_done(win_done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:127];
  int lat = 0;
  bit rmode = 1'b0, rtog = 1'b0, pend = 1'b0;
  int pcnt = 0, nreq = 0, addr_bad = 0, nlog = 0, nexp = 0, pc = 0;
  logic [AW-1:0] paddr = '0, exp_addr = '0;
  logic [19:0] log_off [0:63];
  logic [3:0]  log_be  [0:63];
  logic [31:0] log_dat [0:63];
  logic [19:0] exp_off [0:63];
  logic [3:0]  exp_be  [0:63];
  logic [31:0] exp_dat [0:63];

  always @(negedge clk) begin
    #1;
    mrd_rsp_valid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mrd_rsp_valid = 1'b1;
        mrd_rsp_data  = mem[paddr[8:2]];
        pend = 1'b0;
      end else pcnt--;
    end
    rtog = ~rtog;
    mrd_req_ready = rmode ? rtog : 1'b1;
    if (mrd_req_valid && mrd_req_ready) begin
      pend = 1'b1; pcnt = lat; paddr = mrd_req_addr; nreq++;
      if (mrd_req_addr != exp_addr) addr_bad++;
      exp_addr = mrd_req_addr + AW'(4);
    end
    if (rw_valid && nlog < 64) begin
      log_off[nlog] = rw_offset; log_be[nlog] = rw_be; log_dat[nlog] = rw_data;
      nlog++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic cyc(); @(negedge clk); #2; endtask
  task automatic cycn(input int n); for (int i = 0; i < n; i++) cyc(); endtask

  task automatic load(input int head); pc = head >> 2; nexp = 0; endtask
  task automatic put(input logic [31:0] w); mem[pc] = w; pc++; endtask
  task automatic expw(input logic [19:0] o, input logic [3:0] b, input logic [31:0] d);
    exp_off[nexp] = o; exp_be[nexp] = b; exp_dat[nexp] = d; nexp++;
  endtask
  task automatic ewr(input logic [19:0] o, input logic [3:0] b, input logic [31:0] d);
    put(d); put({8'h01, b, o}); expw(o, b, d);
  endtask
  task automatic eidx(input logic [19:0] o, input int n, input logic [31:0] v);
    put(n); put({8'h09, 4'h0, o});
    for (int i = 0; i < n; i++) begin put(v + i); expw(o, 4'hF, v + i); end
    if (n % 2 == 1) put(32'h0);
  endtask
  task automatic eop(input logic [7:0] op, input logic [31:0] lo, input logic [7:0] up);
    put(lo); put({op, 16'h0, up});
  endtask

  task automatic go_tail(input int head, input int tail);
    head_we = 1'b1; head_wdata = AW'(head); cyc();
    head_we = 1'b0; tail_we = 1'b1; tail_wdata = AW'(tail);
    exp_addr = AW'(head); nlog = 0; nreq = 0; addr_bad = 0;
    cyc(); tail_we = 1'b0;
  endtask
  task automatic go(input int head); go_tail(head, pc * 4); endtask

  task automatic run_idle(input string tag);
    int k;
    for (k = 0; k < 3000; k++) begin
      if (!busy) break;
      cyc();
    end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic pulse_us(); us_tick = 1'b1; cyc(); us_tick = 1'b0; cyc(); endtask
  task automatic pulse_vb(); vblank = 1'b1; cyc(); vblank = 1'b0; cyc(); endtask

  task automatic cmp_log(input string tag);
    chk(nlog == nexp, {tag, " write count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      chk(log_off[i] == exp_off[i], {tag, " offset"}, log_off[i], exp_off[i]);
      chk(log_be[i]  == exp_be[i],  {tag, " byte enables"}, log_be[i], exp_be[i]);
      chk(log_dat[i] == exp_dat[i], {tag, " data"}, log_dat[i], exp_dat[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=hung expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    cycn(4); rst_n = 1'b1; cyc();
    // R1 reset state
    chk(!busy && !prog_irq && !err, "R1 status", {busy, prog_irq, err}, 0);
    chk(!mrd_req_valid && !rw_valid && !win_req, "R1 strobes",
        {mrd_req_valid, rw_valid, win_req}, 0);

    // R2 R3 R12 sweep over latency and ready pattern
    for (int l = 0; l < 4; l++) begin
      for (int r = 0; r < 2; r++) begin
        lat = l; rmode = r[0];
        load(32'h40);
        eop(8'h00, 32'hDEAD_BEEF, 8'h00);
        ewr(20'h00100, 4'hF, 32'hA5A5_0000 + l * 16 + r);
        ewr(20'hABCDE, 4'h3, 32'h1234_5678);
        eidx(20'h00200, 3, 32'h3000_0000 + l);
        eidx(20'h00204, 2, 32'h4000_0000);
        eidx(20'h00208, 0, 32'h0);
        eidx(20'h0020C, 1, 32'h5000_0000);
        ewr(20'h00300, 4'h8, 32'hFFFF_0001);
        eop(8'h07, 32'h0, 8'h00);
        go(32'h40);
        chk(busy, "R5 start busy", busy, 1);
        run_idle("R4 run ends");
        cmp_log("R2 R3 sweep");
        chk(nreq == pc - 16, "R4 words fetched", nreq, pc - 16);
        chk(addr_bad == 0, "R12 fetch address order", addr_bad, 0);
        chk(prog_irq, "R9 irq set", prog_irq, 1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0; cyc();
        chk(!prog_irq, "R9 irq cleared", prog_irq, 0);
      end
    end
    lat = 1; rmode = 1'b0;

    // R6 microsecond wait
    load(32'h80);
    ewr(20'h00010, 4'hF, 32'h1111_1111);
    eop(8'h02, 32'd3, 8'h00);
    ewr(20'h00014, 4'hF, 32'h2222_2222);
    go(32'h80); cycn(30);
    chk(nlog == 1 && busy, "R6 parked before ticks", nlog, 1);
    pulse_us(); pulse_us();
    for (int i = 0; i < 5; i++) pulse_vb();
    cycn(10);
    chk(nlog == 1, "R6 two ticks and vblanks do not release", nlog, 1);
    pulse_us();
    run_idle("R6 finishes");
    cmp_log("R6 after third tick");

    // R6 zero count
    load(32'h80);
    eop(8'h02, 32'd0, 8'h00);
    ewr(20'h00018, 4'hF, 32'h3333_3333);
    go(32'h80); run_idle("R6 zero count no wait");
    cmp_log("R6 zero count");

    // R7 vblank wait
    load(32'h80);
    eop(8'h04, 32'd2, 8'h00);
    ewr(20'h0001C, 4'h1, 32'h4444_4444);
    go(32'h80); cycn(20);
    for (int i = 0; i < 6; i++) pulse_us();
    pulse_vb(); cycn(5);
    chk(nlog == 0 && busy, "R7 one vblank and ticks do not release", nlog, 0);
    pulse_vb();
    run_idle("R7 finishes");
    cmp_log("R7 after second vblank");

    // R8 window waits
    for (int m = 0; m < 3; m++) begin
      logic [7:0] op;
      logic [31:0] lw;
      logic [7:0] up;
      logic [19:0] elo, ehi;
      op = (m == 0) ? 8'h05 : (m == 1) ? 8'h06 : 8'h03;
      if (m == 2) begin lw = 32'd77; up = 8'h00; elo = 20'd77; ehi = 20'd77; end
      else begin
        elo = 20'd10 + m; ehi = 20'h01234 + m;
        lw = {ehi[11:0], elo}; up = ehi[19:12];
      end
      load(32'h80);
      eop(op, lw, up);
      ewr(20'h00020, 4'hF, 32'h5555_0000 + m);
      go(32'h80); cycn(20);
      chk(win_req, "R8 request raised", win_req, 1);
      chk(win_lo == elo, "R8 low line", win_lo, elo);
      chk(win_hi == ehi, "R8 high line", win_hi, ehi);
      chk(win_inside == (m != 1), "R8 mode", win_inside, m != 1);
      chk(nlog == 0, "R8 held until done", nlog, 0);
      win_done = 1'b1; cyc(); win_done = 1'b0;
      run_idle("R8 finishes");
      chk(!win_req, "R8 request dropped", win_req, 0);
      cmp_log("R8 after done");
    end

    // R10 poll and undefined opcodes
    for (int m = 0; m < 2; m++) begin
      load(32'h80);
      ewr(20'h00030, 4'hF, 32'h6666_0000 + m);
      eop(m == 0 ? 8'h0A : 8'h08, 32'h0, 8'h00);
      put(32'h7777_7777); put({8'h01, 4'hF, 20'h00034});
      go(32'h80); run_idle("R10 stops");
      chk(err, "R10 err set", err, 1);
      cmp_log("R10 no write after bad opcode");
      load(32'h80);
      ewr(20'h00038, 4'hF, 32'h8888_8888);
      go(32'h80); run_idle("R10 restart");
      chk(!err, "R10 err cleared by start", err, 0);
      cmp_log("R10 restart");
    end

    // R11 halt during wait
    load(32'h80);
    eop(8'h02, 32'd5, 8'h00);
    put(32'h9999_9999); put({8'h01, 4'hF, 20'h00040});
    go(32'h80); cycn(20);
    chk(busy, "R11 busy before halt", busy, 1);
    halt = 1'b1; cyc();
    chk(!busy, "R11 halt stops", busy, 0);
    halt = 1'b0;
    for (int i = 0; i < 8; i++) pulse_us();
    chk(nlog == 0 && !busy, "R11 no write after halt", nlog, 0);

    // R5 misaligned head
    load(32'h88);
    ewr(20'h00050, 4'hF, 32'hAAAA_AAAA);
    nexp = 0;
    go_tail(32'h88, 32'h90); cycn(10);
    chk(err && !busy, "R5 misaligned sets err", {err, busy}, 2);
    chk(nreq == 0 && nlog == 0, "R5 misaligned fetches nothing", nreq, 0);

    // R4 empty queue
    go_tail(32'h100, 32'h100); cycn(10);
    chk(!busy && nreq == 0, "R4 empty queue", nreq, 0);
    chk(!err, "R5 aligned start clears err", err, 0);

    // R5 end address write while busy ignored
    load(32'h100);
    ewr(20'h00060, 4'hF, 32'hB0B0_0001);
    eop(8'h02, 32'd1, 8'h00);
    ewr(20'h00064, 4'hF, 32'hB0B0_0002);
    go(32'h100);
    ewr(20'h00068, 4'hF, 32'hB0B0_0003);
    nexp = 2;
    cycn(20);
    tail_we = 1'b1; tail_wdata = AW'(pc * 4); head_we = 1'b1; head_wdata = AW'(32'h40);
    cyc(); tail_we = 1'b0; head_we = 1'b0;
    pulse_us();
    run_idle("R5 ignored rewrite run ends");
    cmp_log("R5 end address kept");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule